// File: doc/BRIEF.md
# Base-Displacement Effective Address Generator

This unit forms the virtual address that a memory-referencing instruction will use. It takes a 16-bit address constant from the instruction. The top two bits name one of four fixed base registers in a 16-entry, 32-bit general register file. The low fourteen bits are an unsigned displacement. The unit drives the register file read port, scales the base value up by eight bit positions and adds the displacement, which gives a 40-bit result.

An operation-class input changes how the result is built. Ordinary memory operands and load-address operations take the full sum. Shift-class operations skip the base and pass the displacement through as a shift count. Vector operations clear the two low displacement bits in the sum and reuse those two bits to pick a stride register. The result, the stride code and the stride enable are registered and appear one cycle after the input strobe.

Top module: `base_disp_agen`

## Requirements
- R1: While `in_valid` is high, `gpr_rd_idx` equals 12 + `addr_const[15:14]`, so selector codes 0, 1, 2 and 3 read registers 12, 13, 14 and 15.
- R2: For operation class 0 (memory operand) and class 1 (load address), `ea` = (base << 8) + zero-extended `addr_const[13:0]`. Selector code 0 still adds register 12 and does not mean absolute addressing.
- R3: The 40-bit sum wraps modulo 2^40 and raises no fault.
- R4: For class 2 (shift), `ea` = zero-extended `addr_const[13:0]`, the base is not added, and `stride_en` is 0.
- R5: For class 3 (vector), displacement bits [1:0] are taken as zero in the sum, so `ea[1:0]` is always 0.
- R6: For class 3, `stride_sel` = `addr_const[1:0]`, and `stride_en` is 1 exactly when that value is nonzero (1, 2 and 3 name registers 1, 2 and 3; 0 means no stride).
- R7: For classes 0, 1 and 2, `stride_sel` is 0 and `stride_en` is 0, whatever the low displacement bits are.
- R8: `out_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise. `ea`, `stride_sel` and `stride_en` hold their values while no new strobe arrives.
- R9: While reset is asserted, `out_valid`, `ea`, `stride_sel` and `stride_en` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe: operands are valid this cycle |
| op_class | input | 2 | 0 memory, 1 load address, 2 shift, 3 vector |
| addr_const | input | 16 | Base selector [15:14] and displacement [13:0] |
| gpr_rd_idx | output | 4 | Register file read index (base register) |
| gpr_rd_data | input | 32 | Register file read data, combinational |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| ea | output | 40 | Effective address or shift count |
| stride_sel | output | 2 | Stride register number, 0 when none |
| stride_en | output | 1 | A stride register is named |

## Verification
The unit holds only one register stage, so any internal fault reaches the ports within a cycle. A wrong base index shows up at once on `gpr_rd_idx`, and the next result then carries the wrong register's value shifted into bits [39:8]. A wrong class decode shows one cycle later as extra base bits on shift results, nonzero low bits on vector addresses, or a stride enable on a non-vector operation. A broken capture enable shows as results that drift while `out_valid` is low, or as a strobe that arrives at the wrong time.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic [1:0] {
    OPC_MEM   = 2'd0,
    OPC_LEA   = 2'd1,
    OPC_SHIFT = 2'd2,
    OPC_VEC   = 2'd3
  } op_class_e;
endpackage

// File: rtl/agen_base_select.sv
module agen_base_select #(
  parameter int SEL_W = 2,
  parameter int RF_AW = 4
) (
  input  logic [SEL_W-1:0] base_sel,
  output logic [RF_AW-1:0] rd_idx
);
  // Base registers are the top 2**SEL_W entries of the file.
  localparam int FIRST_BASE = (1 << RF_AW) - (1 << SEL_W);

  always_comb begin
    rd_idx = RF_AW'(FIRST_BASE) + RF_AW'(base_sel);
  end
endmodule

// File: rtl/agen_stride_decode.sv
module agen_stride_decode #(
  parameter int STRIDE_W = 2
) (
  input  logic                is_vec,
  input  logic [STRIDE_W-1:0] low_bits,
  output logic [STRIDE_W-1:0] stride_sel,
  output logic                stride_en
);
  always_comb begin
    if (is_vec) begin
      stride_sel = low_bits;
      stride_en  = |low_bits;
    end else begin
      stride_sel = '0;
      stride_en  = 1'b0;
    end
  end
endmodule

// File: rtl/agen_sum.sv
module agen_sum
  import agen_pkg::*;
#(
  parameter int GPR_W      = 32,
  parameter int BASE_SHIFT = 8,
  parameter int DISP_W     = 14,
  parameter int STRIDE_W   = 2,
  localparam int EA_W      = GPR_W + BASE_SHIFT
) (
  input  op_class_e         op,
  input  logic [GPR_W-1:0]  base,
  input  logic [DISP_W-1:0] disp,
  output logic [EA_W-1:0]   ea_next
);
  logic [DISP_W-1:0] disp_eff;
  logic [EA_W-1:0]   base_scaled;
  logic [EA_W-1:0]   disp_ext;

  always_comb begin
    disp_eff = disp;
    if (op == OPC_VEC) begin
      disp_eff[STRIDE_W-1:0] = '0;
    end
    base_scaled = {base, {BASE_SHIFT{1'b0}}};
    disp_ext    = EA_W'(disp_eff);
    case (op)
      OPC_SHIFT: ea_next = disp_ext;
      default:   ea_next = base_scaled + disp_ext;
    endcase
  end
endmodule

// File: rtl/base_disp_agen.sv
module base_disp_agen
  import agen_pkg::*;
#(
  parameter int GPR_W      = 32,
  parameter int RF_AW      = 4,
  parameter int SEL_W      = 2,
  parameter int DISP_W     = 14,
  parameter int BASE_SHIFT = 8,
  parameter int STRIDE_W   = 2,
  localparam int AC_W      = SEL_W + DISP_W,
  localparam int EA_W      = GPR_W + BASE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op_class,
  input  logic [AC_W-1:0]   addr_const,
  output logic [RF_AW-1:0]  gpr_rd_idx,
  input  logic [GPR_W-1:0]  gpr_rd_data,
  output logic              out_valid,
  output logic [EA_W-1:0]   ea,
  output logic [STRIDE_W-1:0] stride_sel,
  output logic              stride_en
);
  op_class_e            op;
  logic [SEL_W-1:0]     base_sel;
  logic [DISP_W-1:0]    disp;
  logic [EA_W-1:0]      ea_d;
  logic [STRIDE_W-1:0]  ssel_d;
  logic                 sen_d;
  logic                 vld_d;
  logic                 cap_en;

  always_comb begin
    op       = op_class_e'(op_class);
    base_sel = addr_const[AC_W-1:DISP_W];
    disp     = addr_const[DISP_W-1:0];
  end

  agen_base_select #(.SEL_W(SEL_W), .RF_AW(RF_AW)) u_base (
    .base_sel (base_sel),
    .rd_idx   (gpr_rd_idx)
  );

  agen_sum #(
    .GPR_W(GPR_W), .BASE_SHIFT(BASE_SHIFT), .DISP_W(DISP_W), .STRIDE_W(STRIDE_W)
  ) u_sum (
    .op      (op),
    .base    (gpr_rd_data),
    .disp    (disp),
    .ea_next (ea_d)
  );

  agen_stride_decode #(.STRIDE_W(STRIDE_W)) u_stride (
    .is_vec     (op == OPC_VEC),
    .low_bits   (disp[STRIDE_W-1:0]),
    .stride_sel (ssel_d),
    .stride_en  (sen_d)
  );

  // Next-state: the payload loads only on a strobe; the strobe itself always loads.
  always_comb begin
    cap_en = in_valid;
    vld_d  = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea         <= '0;
      stride_sel <= '0;
      stride_en  <= 1'b0;
    end else if (cap_en) begin
      ea         <= ea_d;
      stride_sel <= ssel_d;
      stride_en  <= sen_d;
    end
  end
endmodule

// File: rtl/base_disp_agen_checker.sv
module base_disp_agen_checker
  import agen_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  op_class,
  input logic [15:0] addr_const,
  input logic [3:0]  gpr_rd_idx,
  input logic        out_valid,
  input logic [39:0] ea,
  input logic [1:0]  stride_sel,
  input logic        stride_en
);
  AST_BASE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (gpr_rd_idx == (4'd12 + {2'b00, addr_const[15:14]}))); // R1

  AST_SHIFT_NO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_class == OPC_SHIFT) |=> (ea == {26'd0, $past(addr_const[13:0])} && !stride_en)); // R4

  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_class == OPC_VEC) |=> (ea[1:0] == 2'b00)); // R5

  AST_VEC_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_class == OPC_VEC) |=> (stride_sel == $past(addr_const[1:0]) && stride_en == (stride_sel != 2'b00))); // R6

  AST_NONVEC_NO_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_class != OPC_VEC) |=> (!stride_en && stride_sel == 2'b00)); // R7

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8

  AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(ea) && $stable(stride_sel) && $stable(stride_en))); // R8
endmodule

bind base_disp_agen base_disp_agen_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .op_class   (op_class),
  .addr_const (addr_const),
  .gpr_rd_idx (gpr_rd_idx),
  .out_valid  (out_valid),
  .ea         (ea),
  .stride_sel (stride_sel),
  .stride_en  (stride_en)
);

// File: tb/base_disp_agen_test.sv
`timescale 1ns/1ps
module base_disp_agen_test;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op_class;
  logic [15:0] addr_const;
  logic [3:0]  gpr_rd_idx;
  logic [31:0] gpr_rd_data;
  logic        out_valid;
  logic [39:0] ea;
  logic [1:0]  stride_sel;
  logic        stride_en;

  logic [31:0] gr [16];
  assign gpr_rd_data = gr[gpr_rd_idx];

  typedef struct {
    logic [39:0] ea;
    logic [1:0]  ss;
    logic        se;
    string       req;
  } exp_t;
  exp_t sb[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  base_disp_agen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class),
    .addr_const(addr_const), .gpr_rd_idx(gpr_rd_idx), .gpr_rd_data(gpr_rd_data),
    .out_valid(out_valid), .ea(ea), .stride_sel(stride_sel), .stride_en(stride_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [15:0] ac, input string req);
    exp_t e;
    logic [13:0] d;
    logic [3:0]  bi;
    @(negedge clk);
    in_valid   = 1'b1;
    op_class   = op;
    addr_const = ac;
    #1;
    bi = 4'd12 + {2'b00, ac[15:14]};
    check(gpr_rd_idx == bi, "R1", "base index", {36'd0, gpr_rd_idx}, {36'd0, bi});
    d = ac[13:0];
    if (op == 2'd2) begin
      e.ea = {26'd0, d};
    end else begin
      if (op == 2'd3) d[1:0] = 2'b00;
      e.ea = {gr[bi], 8'h00} + {26'd0, d};
    end
    e.ss  = (op == 2'd3) ? ac[1:0] : 2'b00;
    e.se  = (op == 2'd3) && (ac[1:0] != 2'b00);
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pops expected items as results appear; checks hold when idle (R8).
  initial begin
    logic [39:0] last_ea;
    bit have_last;
    exp_t e;
    have_last = 0;
    last_ea = '0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(0, "R8", "unexpected strobe", 40'd1, 40'd0);
        end else begin
          e = sb.pop_front();
          check(ea == e.ea, e.req, "ea", ea, e.ea);
          check(stride_sel == e.ss && stride_en == e.se, e.req, "stride",
                {37'd0, stride_en, stride_sel}, {37'd0, e.se, e.ss});
          last_ea = ea;
          have_last = 1;
        end
      end else if (have_last) begin
        check(ea == last_ea, "R8", "hold while idle", ea, last_ea);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) gr[i] = 32'h1111_0000 + i;
    gr[1]  = 32'h0000_0004;
    gr[12] = 32'h0001_2345;
    gr[13] = 32'h0000_0000;
    gr[14] = 32'hFFFF_FFFF;
    gr[15] = 32'h8000_0001;
    rst_n = 1'b0; in_valid = 1'b0; op_class = 2'd0; addr_const = 16'h0000;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0, "R9", "out_valid in reset", {39'd0, out_valid}, 40'd0);
    check(ea == 40'd0, "R9", "ea in reset", ea, 40'd0);
    check(stride_sel == 2'd0 && !stride_en, "R9", "stride in reset",
          {37'd0, stride_en, stride_sel}, 40'd0);
    rst_n = 1'b1;
    idle(2);

    drive(2'd0, {2'b00, 14'h0010}, "R2");   // selector 0 still adds GR12
    drive(2'd1, {2'b01, 14'h3FFF}, "R2");   // load address, zero base
    drive(2'd0, {2'b10, 14'h3FFF}, "R3");   // wraps past 2^40
    drive(2'd1, {2'b11, 14'h0101}, "R2");
    idle(3);
    drive(2'd2, {2'b11, 14'h0025}, "R4");   // shift: base ignored
    drive(2'd2, {2'b10, 14'h3FFF}, "R4");
    drive(2'd3, {2'b11, 14'h0123}, "R5");   // vector, low bits 3
    drive(2'd3, {2'b00, 14'h0200}, "R6");   // no stride
    drive(2'd3, {2'b01, 14'h0041}, "R6");   // stride GR1
    drive(2'd3, {2'b10, 14'h3FFE}, "R6");   // stride GR2, wraps
    idle(2);
    drive(2'd0, {2'b00, 14'h0003}, "R7");   // low bits do not make a stride
    drive(2'd1, {2'b01, 14'h0002}, "R7");
    drive(2'd2, {2'b00, 14'h0001}, "R7");
    idle(4);

    check(sb.size() == 0, "R8", "all results delivered", 40'(sb.size()), 40'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule